// File: doc/BRIEF.md
# Bus Cycle Stall Controller

This block sits between a fast CPU core with a 16-bit address bus and two memory targets: a fast on-chip RAM that answers in the same cycle, and a slow external bus paced by a host processor clock. Every CPU cycle, it decodes the address combinationally. Addresses inside a fixed set of windows go to the on-chip RAM, and the CPU proceeds with no wait. All other addresses go to the external bus, and the ready signal drops in that same cycle.

While an external access waits, the CPU holds its address, direction and write data steady. A one-cycle host phase strobe marks the moment at which the external bus can complete the access. In the cycle after the strobe, ready goes high for exactly one cycle, and the CPU finishes the access. For a read, the data latched from the external bus at the strobe is presented to the CPU. For a write, the external write strobe fires during that release cycle and at no other time.

Top module: `bus_stall_ctl`

## Requirements
- R1: An address is internal when it lies in 0x0000–0x2FFF, 0x8000–0xFBFF or 0xFF00–0xFFFF. Every other address is external. `ram_en` is high exactly for internal addresses.
- R2: On an internal address, `cpu_rdy` is high in the same cycle. `ram_we` equals `cpu_we`. `cpu_rdata` is the RAM port's read data.
- R3: On an external address that is not in its release cycle, `cpu_rdy` is low in the same cycle the address is presented.
- R4: During an external wait, `cpu_rdy` stays low until `host_phase` is high. It goes high in the following cycle.
- R5: After a release cycle, `cpu_rdy` is high for only that one cycle. If the next address is also external, `cpu_rdy` is low again.
- R6: An external read pulses `ext_rd_stb` in the cycle in which `host_phase` is high during the wait. The value of `ext_rdata` in that cycle appears on `cpu_rdata` in the release cycle.
- R7: An external write pulses `ext_wr_stb` only in the release cycle, with `ext_addr` and `ext_wdata` equal to the CPU's address and data. The strobe never fires during the wait.
- R8: A `host_phase` pulse during an internal cycle or a release cycle has no effect. A following external access still waits for a new pulse.
- R9: After reset, no release is pending. An external address presented first gives `cpu_rdy` low, and both external strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast CPU clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address, held while `cpu_rdy` is low |
| cpu_we | input | 1 | CPU write (1) or read (0) |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Read data returned to the CPU |
| cpu_rdy | output | 1 | Ready; when low, the CPU repeats the cycle |
| ram_en | output | 1 | On-chip RAM select |
| ram_we | output | 1 | On-chip RAM write enable |
| ram_addr | output | 16 | On-chip RAM address |
| ram_wdata | output | 8 | On-chip RAM write data |
| ram_rdata | input | 8 | On-chip RAM read data, same cycle |
| host_phase | input | 1 | One-cycle strobe marking the host bus completion phase |
| ext_addr | output | 16 | External bus address |
| ext_wdata | output | 8 | External bus write data |
| ext_rdata | input | 8 | External bus read data, valid with `host_phase` |
| ext_rd_stb | output | 1 | External read capture strobe |
| ext_wr_stb | output | 1 | External write strobe |

## Verification
The block's only state is a release flag and a read-data latch, so a fault in either shows up at the ports within one or two cycles. A stuck or extra release flag appears in the next cycle as `cpu_rdy` going high without a prior strobe, staying high for two cycles, or never rising. A wrong latch value appears only when an external read completes, as a `cpu_rdata` mismatch against the memory model. A write strobe fired at the wrong moment corrupts external memory silently; it is caught when that location is read back later.

// File: rtl/bus_stall_ctl.sv
module bus_stall_ctl #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int NWIN = 3,
  parameter logic [NWIN-1:0][AW-1:0] WIN_LO = {16'hFF00, 16'h8000, 16'h0000},
  parameter logic [NWIN-1:0][AW-1:0] WIN_HI = {16'hFFFF, 16'hFBFF, 16'h2FFF}
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cpu_addr,
  input  logic          cpu_we,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  output logic          cpu_rdy,
  output logic          ram_en,
  output logic          ram_we,
  output logic [AW-1:0] ram_addr,
  output logic [DW-1:0] ram_wdata,
  input  logic [DW-1:0] ram_rdata,
  input  logic          host_phase,
  output logic [AW-1:0] ext_addr,
  output logic [DW-1:0] ext_wdata,
  input  logic [DW-1:0] ext_rdata,
  output logic          ext_rd_stb,
  output logic          ext_wr_stb
);

  logic [NWIN-1:0] hit;
  logic            is_int;
  logic            rel_q;
  logic            ext_wait;
  logic [DW-1:0]   rd_q;

  for (genvar i = 0; i < NWIN; i++) begin : g_win
    logic [AW-1:0] off;
    assign off    = cpu_addr - WIN_LO[i];
    assign hit[i] = off <= (WIN_HI[i] - WIN_LO[i]);
  end

  assign is_int   = |hit;
  assign ext_wait = !is_int && !rel_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rel_q <= 1'b0;
      rd_q  <= '0;
    end else begin
      rel_q <= ext_wait && host_phase;
      if (ext_rd_stb) rd_q <= ext_rdata;
    end
  end

  assign cpu_rdy    = is_int || rel_q;
  assign cpu_rdata  = is_int ? ram_rdata : rd_q;

  assign ram_en     = is_int;
  assign ram_we     = is_int && cpu_we;
  assign ram_addr   = cpu_addr;
  assign ram_wdata  = cpu_wdata;

  assign ext_addr   = cpu_addr;
  assign ext_wdata  = cpu_wdata;
  assign ext_rd_stb = ext_wait && host_phase && !cpu_we;
  assign ext_wr_stb = !is_int && rel_q && cpu_we;

endmodule

module bus_stall_ctl_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_we,
  input logic          cpu_rdy,
  input logic          ram_en,
  input logic          host_phase,
  input logic          ext_rd_stb,
  input logic          ext_wr_stb,
  input logic [DW-1:0] ext_rdata,
  input logic [DW-1:0] cpu_rdata
);

  a_r2_internal_no_wait: assert property (@(posedge clk) disable iff (!rst_n)
    ram_en |-> cpu_rdy);

  a_r4_rise_after_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_rdy && host_phase) |=> cpu_rdy);

  a_r5_single_release: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rdy && !ram_en) |=> (ram_en || !cpu_rdy));

  a_r6_read_capture_in_wait: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rd_stb |-> (!cpu_rdy && host_phase && !cpu_we));

  a_r6_read_data_on_release: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rd_stb |=> (cpu_rdy && cpu_rdata == $past(ext_rdata)));

  a_r7_write_in_release: assert property (@(posedge clk) disable iff (!rst_n)
    ext_wr_stb |-> (cpu_rdy && !ram_en && $past(host_phase)));

endmodule

bind bus_stall_ctl bus_stall_ctl_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_rdy(cpu_rdy),
  .ram_en(ram_en), .host_phase(host_phase), .ext_rd_stb(ext_rd_stb),
  .ext_wr_stb(ext_wr_stb), .ext_rdata(ext_rdata), .cpu_rdata(cpu_rdata)
);

// File: tb/bus_stall_ctl_tb_top.sv
module bus_stall_ctl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic        cpu_we = 1'b0;
  logic [7:0]  cpu_wdata = '0;
  logic [7:0]  cpu_rdata;
  logic        cpu_rdy;
  logic        ram_en, ram_we;
  logic [15:0] ram_addr;
  logic [7:0]  ram_wdata, ram_rdata;
  logic        host_phase = 1'b0;
  logic [15:0] ext_addr;
  logic [7:0]  ext_wdata, ext_rdata;
  logic        ext_rd_stb, ext_wr_stb;

  logic [7:0] imem [1024];
  logic [7:0] xmem [1024];
  logic [7:0] ref_i [1024];
  logic [7:0] ref_x [1024];

  int    nchk = 0;
  int    nfail = 0;
  int    ncyc = 0;
  bit    exp_rel = 1'b0;
  bit    last_rdy = 1'b0;
  string ctx = "";

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_stall_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_we(cpu_we),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_rdy(cpu_rdy),
    .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata), .host_phase(host_phase),
    .ext_addr(ext_addr), .ext_wdata(ext_wdata), .ext_rdata(ext_rdata),
    .ext_rd_stb(ext_rd_stb), .ext_wr_stb(ext_wr_stb)
  );

  assign ram_rdata = imem[ram_addr[9:0]];
  assign ext_rdata = xmem[ext_addr[9:0]];

  always @(posedge clk) begin
    if (ram_we)     imem[ram_addr[9:0]] <= ram_wdata;
    if (ext_wr_stb) xmem[ext_addr[9:0]] <= ext_wdata;
  end

  function automatic bit win(input logic [15:0] a);
    return (a <= 16'h2FFF) || (a >= 16'h8000 && a <= 16'hFBFF) || (a >= 16'hFF00);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, ctx, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  endtask

  always @(posedge clk) begin
    ncyc++;
    if (ncyc > 150000) begin
      nfail++;
      $display("FAIL watchdog %s act=%0d exp=0", ctx, ncyc);
      summary();
    end
  end

  // One fast cycle: apply inputs at negedge, check outputs, update the reference model.
  task automatic cyc(input logic [15:0] a, input bit w, input logic [7:0] d, input bit p);
    bit inw, erdy;
    logic [7:0] expd;
    cpu_addr = a; cpu_we = w; cpu_wdata = d; host_phase = p;
    #1;
    inw  = win(a);
    erdy = inw || exp_rel;
    chk("R1", ram_en, inw);
    chk(inw ? "R2" : (exp_rel ? "R4" : "R3"), cpu_rdy, erdy);
    chk("R2", ram_we, inw && w);
    chk("R6", ext_rd_stb, !inw && !exp_rel && p && !w);
    chk("R7", ext_wr_stb, !inw && exp_rel && w);
    if (!inw && exp_rel && w) begin
      chk("R7", ext_addr, a);
      chk("R7", ext_wdata, d);
    end
    if (erdy && !w) begin
      expd = inw ? ref_i[a[9:0]] : ref_x[a[9:0]];
      chk(inw ? "R2" : "R6", cpu_rdata, expd);
    end
    if (erdy && w) begin
      if (inw) ref_i[a[9:0]] = d;
      else     ref_x[a[9:0]] = d;
    end
    last_rdy = erdy;
    exp_rel  = !inw && !exp_rel && p;
    @(negedge clk);
  endtask

  task automatic acc(input logic [15:0] a, input bit w, input logic [7:0] d, input int n);
    if (win(a)) cyc(a, w, d, 1'b0);
    else begin
      repeat (n) cyc(a, w, d, 1'b0);
      cyc(a, w, d, 1'b1);
      cyc(a, w, d, 1'b0);
    end
  endtask

  initial begin
    logic [15:0] ra;
    bit rw, rp;
    logic [7:0] rd;
    void'($urandom(32'd2024));
    for (int i = 0; i < 1024; i++) begin
      imem[i] = 8'(i) ^ 8'h5A; ref_i[i] = 8'(i) ^ 8'h5A;
      xmem[i] = 8'(i * 3);     ref_x[i] = 8'(i * 3);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9: first external address after reset must stall with strobes low
    ctx = "R9 reset";
    cyc(16'h3000, 1'b0, 8'h00, 1'b0);
    cyc(16'h3000, 1'b0, 8'h00, 1'b1);
    cyc(16'h3000, 1'b0, 8'h00, 1'b0);

    // R1: window boundaries
    ctx = "R1 edges";
    acc(16'h0000, 0, 0, 1); acc(16'h2FFF, 0, 0, 1); acc(16'h3000, 0, 0, 1);
    acc(16'h7FFF, 0, 0, 1); acc(16'h8000, 0, 0, 1); acc(16'hFBFF, 0, 0, 1);
    acc(16'hFC00, 0, 0, 1); acc(16'hFEFF, 0, 0, 1); acc(16'hFF00, 0, 0, 1);
    acc(16'hFFFF, 0, 0, 1);

    // R5: back-to-back external reads, the second must stall again
    ctx = "R5 back-to-back";
    acc(16'h4010, 0, 0, 2);
    acc(16'h4011, 0, 0, 0);

    // R7: external write then read back
    ctx = "R7 write-readback";
    acc(16'h5123, 1, 8'hC3, 3);
    acc(16'h5123, 0, 8'h00, 1);
    acc(16'h0123, 1, 8'h3C, 0);
    acc(16'h0123, 0, 8'h00, 0);

    // R8: phase during internal and release cycles ignored
    ctx = "R8 stray phase";
    cyc(16'h8123, 1'b0, 8'h00, 1'b1);
    cyc(16'h6000, 1'b0, 8'h00, 1'b0);
    cyc(16'h6000, 1'b0, 8'h00, 1'b1);
    cyc(16'h6000, 1'b0, 8'h00, 1'b1);
    cyc(16'h6001, 1'b0, 8'h00, 1'b0);
    cyc(16'h6001, 1'b0, 8'h00, 1'b1);
    cyc(16'h6001, 1'b0, 8'h00, 1'b0);

    // Random mix, address held while stalled
    ctx = "random";
    last_rdy = 1'b1;
    ra = '0; rw = 0; rd = '0;
    for (int i = 0; i < 4000; i++) begin
      if (last_rdy) begin
        ra = 16'($urandom);
        if ($urandom % 2 == 0) ra[15:10] = 6'($urandom % 4) | 6'h3C;
        rw = ($urandom % 3) == 0;
        rd = 8'($urandom);
      end
      rp = ($urandom % 3) == 0;
      cyc(ra, rw, rd, rp);
    end
    while (!last_rdy) cyc(ra, rw, rd, 1'b1);
    summary();
  end
endmodule